// File: doc/BRIEF.md
# Dual-Clock Pulse Catch Flag

This block turns an input pulse of any width, including one much narrower than a system clock period, into a flag that the system clock domain reads and clears. Two flip-flops form a twisted ring of two. The rising edge of the pulse input clocks the set-side flop, and the system clock clocks the clear-side flop. An edge on the set side makes the two flop outputs differ. An accepted clear makes them equal again. Their exclusive-OR is the raw flag. The raw flag is asynchronous to the system clock, so a resynchroniser chain brings it into the system domain. The design contains no combinational feedback and no level-sensitive storage.

A small state machine in the system domain decides when a clear request may reach the clear-side flop. In ST_IDLE the synchronised flag is 0, or has just become 1. The transition IDLE->HELD happens when the flag reads 1 and no clear is requested. The transition IDLE->DRAIN happens when the flag reads 1 and a clear is requested in the same cycle. In ST_HELD the flag is 1 and waits for software. HELD->DRAIN happens on a clear request. HELD->IDLE covers a flag that falls without a clear. ST_DRAIN lasts one clock edge per resynchroniser stage, so that the synchronised flag can show the result of the clear. Clear requests are ignored in this state. The transition DRAIN->IDLE is taken when the stage count runs out.

The set enable is sampled at the pulse edge, so it must be generated in the pulse domain. The clear request is sampled at the rising system clock edge.

Top module: `pulse_flag_catcher`

## Requirements
- R1: An active-low asynchronous reset forces both ring flops and every resynchroniser stage to 0, so flag_out reads 0 during reset and after it.
- R2: A rising edge on pulse_in with set_en high sets the flag, even when pulse_in stays high for less than one clk period.
- R3: With the default two resynchroniser stages, flag_out reads 0 after the first rising clk edge that follows the pulse edge and reads 1 after the second.
- R4: Once set, flag_out stays 1 for as long as no clear is accepted.
- R5: A clr_req sampled high at clk edge E, while flag_out is 1 and the state machine is not in ST_DRAIN, is accepted. flag_out still reads 1 after edges E and E+1 and reads 0 after edge E+2.
- R6: A clr_req while flag_out is 0 has no effect. The flag stays 0, and a later pulse still sets it with the R3 timing.
- R7: Further pulses that arrive before a clear leave the flag at 1, and a single accepted clear returns it to 0. Pulses are not counted.
- R8: A pulse_in edge while set_en is low is ignored, and flag_out stays 0.
- R9: For the two clk edges that follow an accepted clear (ST_DRAIN), clr_req is ignored. A pulse that arrives in that window keeps flag_out at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; clocks the clear-side flop, the resynchroniser and the state machine |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Pulse to catch; its rising edge clocks the set-side flop |
| set_en | input | 1 | Set enable, sampled at the rising edge of pulse_in |
| clr_req | input | 1 | Clear request, sampled at the rising edge of clk |
| flag_out | output | 1 | Flag synchronised to clk: 1 = pulse caught and not yet cleared |

## Verification
The catch path is driven with a sub-nanosecond pulse, with repeated pulses before any clear, and with a pulse while set_en is low. These separate a real edge capture from a level sample, and a held flag from a counted one. The clear path is driven with a request while the flag is idle, which would expose a ring that toggles on a blind clear. It is also driven with a request held across the drain window while a new pulse lands. That case separates a correctly blocked repeat clear from one that wipes out a fresh catch. Each of these cases is sampled on the exact clk edges where the resynchroniser latency predicts a change. An asynchronous reset while the flag is set confirms that the flag falls without waiting for a clock.

// File: rtl/pc_pkg.sv
`timescale 1ns/1ps
package pc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HELD  = 2'd1,
        ST_DRAIN = 2'd2
    } clr_state_t;
endpackage

// File: rtl/pc_set_flop.sv
`timescale 1ns/1ps
// Set-side ring flop: loads the inverse of the opposite flop on a pulse edge.
module pc_set_flop (
    input  logic pulse_clk,
    input  logic rst_n,
    input  logic en,
    input  logic opp_q,
    output logic q
);
    always_ff @(posedge pulse_clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (en) begin
            q <= ~opp_q;
        end
    end
endmodule

// File: rtl/pc_clear_flop.sv
`timescale 1ns/1ps
// Clear-side ring flop: copies the set-side flop on an enabled system edge.
module pc_clear_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic opp_q,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (en) begin
            q <= opp_q;
        end
    end
endmodule

// File: rtl/pc_sync_chain.sv
`timescale 1ns/1ps
// Multi-stage resynchroniser into the clk domain.
module pc_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[0] <= 1'b0;
                    else        stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[i] <= 1'b0;
                    else        stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pc_clear_fsm.sv
`timescale 1ns/1ps
// Gates clear requests: accepted only with flag set, then blocked while
// the resynchroniser drains the result of the clear.
module pc_clear_fsm
    import pc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_sync,
    input  logic clr_req,
    output logic clr_en,
    output logic drain_o
);
    localparam int CW = (SYNC_STAGES < 2) ? 1 : $clog2(SYNC_STAGES);
    localparam logic [CW-1:0] LAST = CW'(SYNC_STAGES - 1);

    clr_state_t state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (flag_sync && clr_req) begin
                    state_nx = ST_DRAIN;
                    cnt_nx   = '0;
                end else if (flag_sync) begin
                    state_nx = ST_HELD;
                end
            end
            ST_HELD: begin
                if (clr_req) begin
                    state_nx = ST_DRAIN;
                    cnt_nx   = '0;
                end else if (!flag_sync) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_DRAIN: begin
                if (cnt == LAST) begin
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_comb begin
        drain_o = (state == ST_DRAIN);
        clr_en  = clr_req && flag_sync && (state != ST_DRAIN);
    end
endmodule

// File: rtl/pulse_flag_catcher.sv
`timescale 1ns/1ps
module pulse_flag_catcher #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    input  logic set_en,
    input  logic clr_req,
    output logic flag_out
);
    logic q_set;
    logic q_clr;
    logic raw_flag;
    logic clr_en;
    logic in_drain;

    pc_set_flop u_set (
        .pulse_clk (pulse_in),
        .rst_n     (rst_n),
        .en        (set_en),
        .opp_q     (q_clr),
        .q         (q_set)
    );

    pc_clear_flop u_clr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (clr_en),
        .opp_q (q_set),
        .q     (q_clr)
    );

    assign raw_flag = q_set ^ q_clr;

    pc_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_flag),
        .q     (flag_out)
    );

    pc_clear_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_sync (flag_out),
        .clr_req   (clr_req),
        .clr_en    (clr_en),
        .drain_o   (in_drain)
    );
endmodule

// File: rtl/pc_flag_checker.sv
`timescale 1ns/1ps
module pc_flag_checker (
    input logic clk,
    input logic rst_n,
    input logic clr_req,
    input logic flag_out,
    input logic q_set,
    input logic q_clr,
    input logic raw_flag,
    input logic in_drain
);
    // R1: reset holds ring and flag at 0
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_zero: assert (!flag_out && !q_set && !q_clr)
                else $error("R1 reset state not zero");
        end
    end

    // R6: a clear while the flag reads 0 never moves the clear-side flop
    a_r6_idle_clear_inert: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_out |=> $stable(q_clr));

    // R9: during drain the clear-side flop is frozen
    a_r9_drain_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        in_drain |=> $stable(q_clr));

    // R5: accepted clear copies set-side value and enters drain
    a_r5_clear_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_out && clr_req && !in_drain) |=> (in_drain && (q_clr == $past(q_set))));

    // R3: flag rises only after the raw flag was seen two edges earlier
    a_r3_rise_from_raw: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_out) |-> $past(raw_flag, 2));
endmodule

bind pulse_flag_catcher pc_flag_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_req  (clr_req),
    .flag_out (flag_out),
    .q_set    (q_set),
    .q_clr    (q_clr),
    .raw_flag (raw_flag),
    .in_drain (in_drain)
);

// File: tb/test_pulse_flag_catcher.sv
`timescale 1ns/1ps
module test_pulse_flag_catcher;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pulse_in = 1'b0;
    logic set_en = 1'b1;
    logic clr_req = 1'b0;
    logic flag_out;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    pulse_flag_catcher i_pulse_flag_catcher (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (pulse_in),
        .set_en   (set_en),
        .clr_req  (clr_req),
        .flag_out (flag_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: flag_out=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Advance to 1 ns after the next rising edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic fire();
        pulse_in = 1'b1;
        #0.5;
        pulse_in = 1'b0;
    endtask

    // Accepted clear with full R5 timing check; caller is at edge+1ns.
    task automatic clear_flag(input string req);
        clr_req = 1'b1;
        step();             // edge E
        clr_req = 1'b0;
        check(req, flag_out, 1'b1);
        step();             // E+1
        check(req, flag_out, 1'b1);
        step();             // E+2
        check(req, flag_out, 1'b0);
        step();
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        check("R1 in reset", flag_out, 1'b0);
        rst_n = 1'b1;
        step();
        step();
        check("R1 after reset", flag_out, 1'b0);
    endtask

    task automatic t_narrow_pulse();
        fire();
        step();
        check("R3 first edge", flag_out, 1'b0);
        step();
        check("R2 R3 second edge", flag_out, 1'b1);
    endtask

    task automatic t_hold();
        for (int i = 0; i < 8; i++) begin
            step();
            check("R4 held", flag_out, 1'b1);
        end
        clear_flag("R5 clear timing");
        check("R5 stays clear", flag_out, 1'b0);
    endtask

    task automatic t_idle_clear();
        clr_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R6 idle clear", flag_out, 1'b0);
        end
        clr_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R6 after idle clear", flag_out, 1'b0);
        end
        fire();
        step();
        check("R6 pulse first edge", flag_out, 1'b0);
        step();
        check("R6 pulse sets", flag_out, 1'b1);
        step();
        clear_flag("R6 cleanup");
    endtask

    task automatic t_double_pulse();
        fire();
        step();
        #0.5;
        fire();
        step();
        check("R7 two pulses", flag_out, 1'b1);
        fire();
        step();
        step();
        check("R7 three pulses", flag_out, 1'b1);
        clear_flag("R7 single clear");
        step();
        check("R7 no residue", flag_out, 1'b0);
    endtask

    task automatic t_set_disabled();
        set_en = 1'b0;
        #0.2;
        fire();
        for (int i = 0; i < 4; i++) begin
            step();
            check("R8 set disabled", flag_out, 1'b0);
        end
        set_en = 1'b1;
    endtask

    task automatic t_drain_pulse();
        fire();
        step();
        step();
        check("R9 setup", flag_out, 1'b1);
        clr_req = 1'b1;
        step();             // E: clear accepted
        #0.5;
        fire();             // new catch inside the drain window
        step();             // E+1: request still high, ignored
        check("R9 drain E+1", flag_out, 1'b1);
        step();             // E+2
        clr_req = 1'b0;
        check("R9 drain E+2", flag_out, 1'b1);
        for (int i = 0; i < 4; i++) begin
            step();
            check("R9 new catch kept", flag_out, 1'b1);
        end
        clear_flag("R9 cleanup");
    endtask

    task automatic t_async_reset();
        fire();
        step();
        step();
        check("R1 setup", flag_out, 1'b1);
        rst_n = 1'b0;
        #0.5;
        check("R1 async drop", flag_out, 1'b0);
        step();
        rst_n = 1'b1;
        step();
        step();
        check("R1 after release", flag_out, 1'b0);
    endtask

    initial begin
        t_reset();
        t_narrow_pulse();
        t_hold();
        t_idle_clear();
        t_double_pulse();
        t_set_disabled();
        t_drain_pulse();
        t_async_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule